// File: doc/BRIEF.md
# SPI Burst Master

This block is a memory-mapped SPI master that moves bytes in bursts. Software fills a byte-wide transmit FIFO and loads three live down-counters: the total burst length, the number of bytes taken from the transmit FIFO, and a single-mode transmit count. It then sets a start bit. The engine shifts out the FIFO bytes, pads the rest of the burst with dummy bytes and captures one received byte per exchanged byte into a receive FIFO. The start bit clears itself when the burst is over, so software polls it for completion.

The counters have no shadow copy. They count down in place, read zero after a burst, and must be written again before the next one. A discard bit keeps receive data out of the receive FIFO. Chip select is driven by register fields: software either holds the selected line at a level it chooses, or lets the engine pull the selected line low for the length of a burst. The engine is a four-state machine. IDLE accepts a start (start-accept) and moves to LOAD. LOAD fetches a byte and moves to SHIFT (load-done). SHIFT runs sixteen SCLK edges and moves to TAIL (last-edge). TAIL completes the byte, then returns to LOAD (next-byte) or to IDLE (burst-end). Any state returns to IDLE when the controller is switched off (abort). SCLK toggles once every `HALF_PERIOD` system clocks.

Top module: `spi_burst_master`

## Requirements
- R1: After reset every register reads 0, SCLK and MOSI are low and all four `ss_n` lines are high. The register word addresses are: 0 control, 1 transfer, 2 FIFO control, 3 burst count, 4 transmit count, 5 single-mode count, 6 transmit data (write), 7 receive data (read).
- R2: A burst runs only while control bit 0 (enable) and bit 1 (master) are both 1. Otherwise a written start bit reads back 0 and SCLK stays still. Clearing enable during a burst stops SCLK and clears the start bit.
- R3: Transfer bit 31 (start) reads 1 while a burst runs and clears by itself after the last byte. A burst count of 0 completes with no SCLK edge.
- R4: The burst, transmit and single-mode counters (24 bits each) drop by one per exchanged byte. The transmit and single-mode counters stop at 0. All three read 0 after a completed burst.
- R5: Each byte takes 8 SCLK cycles, most significant bit first. While the transmit counter is non-zero the byte comes from the transmit FIFO in write order. Every later byte, and any byte needed while the FIFO is empty, is sent as 0x00.
- R6: Each received byte is pushed into the receive FIFO. A read of address 7 returns the oldest byte, with the first bit received in bit 7.
- R7: With transfer bit 8 (discard) set, received bytes are not stored.
- R8: Transfer bit 1 (polarity) gives the SCLK idle level. Transfer bit 0 (phase) = 0 samples on the leading edge and changes MOSI on the trailing edge; phase = 1 does the reverse.
- R9: Transfer bit 11 (late sample) moves the MISO capture one system clock after the capture edge.
- R10: Transfer bits 5:4 select one of four lines, and lines not selected stay high. With bit 6 (software owner) set, the selected line follows bit 7 (level). With bit 6 clear, the selected line is low exactly while a burst runs.
- R11: A write to transmit data while that FIFO is full is dropped. A read of receive data while that FIFO is empty returns 0. Neither moves the FIFO pointers.
- R12: FIFO control bit 31 empties the receive FIFO and bit 15 empties the transmit FIFO. Both bits read back 0 one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at address 7) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Chip-select lines, low is active |

## Verification
The assertions assume that software leaves polarity, phase and the late-sample bit unchanged while the start bit reads 1. They also assume that software does not write the counters during a burst. The SCLK return-to-idle and counter-decrement properties rely on both. They further assume that `HALF_PERIOD` is at least 2, so that a late capture lands before the next edge. The stimulus changes transfer fields only between bursts, polls the start bit to 0 before any new write, and writes the counters only in the idle gaps. The one exception is the abort case, which clears enable in the middle of a burst; the properties for that case are written to cover it.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

    // Register word addresses
    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_XFER  = 3'd1;
    localparam logic [2:0] A_FIFO  = 3'd2;
    localparam logic [2:0] A_BURST = 3'd3;
    localparam logic [2:0] A_TXC   = 3'd4;
    localparam logic [2:0] A_STC   = 3'd5;
    localparam logic [2:0] A_TXD   = 3'd6;
    localparam logic [2:0] A_RXD   = 3'd7;

    // Control register bits
    localparam int B_EN  = 0;
    localparam int B_MST = 1;

    // Transfer register bits
    localparam int B_CPHA  = 0;
    localparam int B_CPOL  = 1;
    localparam int B_SELLO = 4;
    localparam int B_OWN   = 6;
    localparam int B_LVL   = 7;
    localparam int B_DISC  = 8;
    localparam int B_SDEL  = 11;
    localparam int B_START = 31;

    // FIFO control bits
    localparam int B_TXRST = 15;
    localparam int B_RXRST = 31;

    localparam int NUM_SS = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_TAIL
    } eng_state_e;

endpackage

// File: rtl/spi_bm_fifo.sv
module spi_bm_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R11: occupancy never exceeds the depth
    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R11: a push into a full FIFO leaves the level unchanged
    p_full_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && count == $past(count)));

endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine
    import spi_bm_pkg::*;
#(
    parameter int HALF_PERIOD = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       start,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       sdelay,
    input  logic       burst_zero,
    input  logic       burst_last,
    input  logic       tx_take,
    input  logic       tx_empty,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       tx_pop,
    output logic       byte_done,
    output logic       burst_done,
    output logic [7:0] rx_byte
);
    localparam int TW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;

    eng_state_e    state, state_n;
    logic [TW-1:0] tick;
    logic [3:0]    ecnt;
    logic [7:0]    txsh, rxsh;
    logic          pend;
    logic          tick_end, samp_edge, last_drive;

    assign tick_end   = (tick == TW'(HALF_PERIOD - 1));
    assign samp_edge  = ecnt[0] ^ ~cpha;            // leading edges are even
    assign last_drive = cpha ? (ecnt == 4'd0) : (ecnt == 4'd15);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (run && start && !burst_zero) state_n = ST_LOAD;
            ST_LOAD:  state_n = ST_SHIFT;
            ST_SHIFT: if (tick_end && ecnt == 4'd15) state_n = ST_TAIL;
            ST_TAIL:  state_n = burst_last ? ST_IDLE : ST_LOAD;
        endcase
        if (!run) state_n = ST_IDLE;
    end

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        tx_pop     = run && (state == ST_LOAD) && tx_take && !tx_empty;
        byte_done  = run && (state == ST_TAIL);
        burst_done = run && (((state == ST_TAIL) && burst_last) ||
                             ((state == ST_IDLE) && start && burst_zero));
        rx_byte    = pend ? {rxsh[6:0], miso} : rxsh;
        mosi       = txsh[7];
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk <= 1'b0;
            tick <= '0;
            ecnt <= '0;
            txsh <= '0;
            rxsh <= '0;
            pend <= 1'b0;
        end else begin
            pend <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    sclk <= cpol;
                    tick <= '0;
                    ecnt <= '0;
                    txsh <= '0;
                end
                ST_LOAD: begin
                    txsh <= tx_pop ? tx_byte : 8'h00;
                    tick <= '0;
                    ecnt <= '0;
                end
                ST_SHIFT: begin
                    if (pend) rxsh <= {rxsh[6:0], miso};
                    tick <= tick_end ? '0 : tick + 1'b1;
                    if (tick_end) begin
                        sclk <= ~sclk;
                        ecnt <= ecnt + 1'b1;
                        if (samp_edge) begin
                            if (sdelay) pend <= 1'b1;
                            else        rxsh <= {rxsh[6:0], miso};
                        end else if (!last_drive) begin
                            txsh <= {txsh[6:0], 1'b0};
                        end
                    end
                end
                ST_TAIL: begin
                    rxsh <= rx_byte;
                end
            endcase
        end
    end

    // R2: a controller switched off returns to IDLE at the next edge
    p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state == ST_IDLE));

    // R8: after sixteen toggles SCLK is back at its idle level
    p_sclk_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> (sclk == cpol));

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_bm_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int CNT_W       = 24,
    parameter int HALF_PERIOD = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  ss_n
);
    localparam int PAD = 32 - CNT_W;

    logic en_q, mst_q, cpha_q, cpol_q, own_q, lvl_q, disc_q, sdel_q;
    logic start_q, txrst_q, rxrst_q;
    logic [1:0]       sel_q;
    logic [CNT_W-1:0] burst_q, txc_q, stc_q;

    logic run, busy, tx_pop, byte_done, burst_done;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0] tx_dout, rx_dout, rx_byte;
    logic wr_ctrl, wr_xfer, wr_fifo, wr_burst, wr_txc, wr_stc, wr_txd, rd_rxd;
    logic unused_sigs;

    assign run      = en_q & mst_q;
    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_xfer  = bus_wr && (bus_addr == A_XFER);
    assign wr_fifo  = bus_wr && (bus_addr == A_FIFO);
    assign wr_burst = bus_wr && (bus_addr == A_BURST);
    assign wr_txc   = bus_wr && (bus_addr == A_TXC);
    assign wr_stc   = bus_wr && (bus_addr == A_STC);
    assign wr_txd   = bus_wr && (bus_addr == A_TXD);
    assign rd_rxd   = bus_rd && (bus_addr == A_RXD);
    assign unused_sigs = ^{bus_wdata, tx_full, rx_full};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {en_q, mst_q, cpha_q, cpol_q, own_q, lvl_q, disc_q, sdel_q} <= '0;
            {start_q, txrst_q, rxrst_q} <= '0;
            sel_q   <= '0;
            burst_q <= '0;
            txc_q   <= '0;
            stc_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= bus_wdata[B_EN];
                mst_q <= bus_wdata[B_MST];
            end
            if (wr_xfer) begin
                cpha_q <= bus_wdata[B_CPHA];
                cpol_q <= bus_wdata[B_CPOL];
                sel_q  <= bus_wdata[B_SELLO +: 2];
                own_q  <= bus_wdata[B_OWN];
                lvl_q  <= bus_wdata[B_LVL];
                disc_q <= bus_wdata[B_DISC];
                sdel_q <= bus_wdata[B_SDEL];
            end
            start_q <= run && ((wr_xfer && bus_wdata[B_START]) || (start_q && !burst_done));
            txrst_q <= wr_fifo && bus_wdata[B_TXRST];
            rxrst_q <= wr_fifo && bus_wdata[B_RXRST];
            if (wr_burst)       burst_q <= bus_wdata[CNT_W-1:0];
            else if (byte_done) burst_q <= burst_q - 1'b1;
            if (wr_txc)                          txc_q <= bus_wdata[CNT_W-1:0];
            else if (byte_done && txc_q != '0)   txc_q <= txc_q - 1'b1;
            if (wr_stc)                          stc_q <= bus_wdata[CNT_W-1:0];
            else if (byte_done && stc_q != '0)   stc_q <= stc_q - 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = {30'b0, mst_q, en_q};
            A_XFER:  bus_rdata = {start_q, 19'b0, sdel_q, 2'b0, disc_q, lvl_q, own_q,
                                  sel_q, 2'b0, cpol_q, cpha_q};
            A_FIFO:  bus_rdata = {rxrst_q, 15'b0, txrst_q, 15'b0};
            A_BURST: bus_rdata = {{PAD{1'b0}}, burst_q};
            A_TXC:   bus_rdata = {{PAD{1'b0}}, txc_q};
            A_STC:   bus_rdata = {{PAD{1'b0}}, stc_q};
            A_RXD:   bus_rdata = {24'b0, rx_empty ? 8'h00 : rx_dout};
            default: bus_rdata = '0;
        endcase
    end

    for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
        assign ss_n[i] = (sel_q == 2'(i)) ? (own_q ? lvl_q : ~busy) : 1'b1;
    end

    spi_bm_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(txrst_q), .push(wr_txd), .din(bus_wdata[7:0]),
        .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full)
    );

    spi_bm_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(rxrst_q), .push(byte_done && !disc_q), .din(rx_byte),
        .pop(rd_rxd), .dout(rx_dout), .empty(rx_empty), .full(rx_full)
    );

    spi_bm_engine #(.HALF_PERIOD(HALF_PERIOD)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .start(start_q), .cpol(cpol_q), .cpha(cpha_q),
        .sdelay(sdel_q), .burst_zero(burst_q == '0), .burst_last(burst_q == CNT_W'(1)),
        .tx_take(txc_q != '0), .tx_empty(tx_empty), .tx_byte(tx_dout), .miso(miso),
        .sclk(sclk), .mosi(mosi), .busy(busy), .tx_pop(tx_pop), .byte_done(byte_done),
        .burst_done(burst_done), .rx_byte(rx_byte)
    );

    // R3: the start bit only drops at burst end or when switched off
    p_start_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_q) |-> $past(burst_done || !run));

    // R4: each finished byte lowers the burst counter by one
    p_burst_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !wr_burst) |=> (burst_q == $past(burst_q) - 1'b1));

    // R5: the engine never pops an empty transmit FIFO
    p_pop_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    // R10: at most one chip-select line is active
    p_one_ss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ss_n) <= 1);

    // R12: a FIFO reset bit clears itself one cycle later
    p_rst_selfclear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (txrst_q && !wr_fifo) |=> (!txrst_q && tx_empty));

endmodule

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb;
    import spi_bm_pkg::*;

    localparam int DEPTH = 64;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic sclk, mosi, miso;
    logic [3:0] ss_n;
    logic pulse_mode = 1'b0, pulse_v = 1'b0;

    assign miso = pulse_mode ? pulse_v : ~mosi;
    always #5 clk = ~clk;

    spi_burst_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ss_n(ss_n)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] txm[$], mosi_q[$], rx_q[$];
    string tag_q[$];
    logic c_cpol = 0, c_cpha = 0, c_own = 0, c_lvl = 0, c_disc = 0, c_sdel = 0;
    logic [1:0] c_sel = 0;
    int sclk_edges = 0;
    logic mon_en = 0;
    int mbits = 0;
    logic [7:0] mbyte = 0;

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: rebuild MOSI bytes at the capture edges and score them
    always @(sclk) begin
        sclk_edges++;
        if (mon_en && (sclk == (c_cpol == c_cpha))) begin
            mbyte = {mbyte[6:0], mosi};
            mbits++;
            if (mbits == 8) begin
                mbits = 0;
                if (mosi_q.size() == 0) check("R5 unexpected MOSI byte", {24'b0, mbyte}, 32'hFFFF_FFFF);
                else check(tag_q.pop_front(), {24'b0, mbyte}, {24'b0, mosi_q.pop_front()});
            end
        end
    end

    // MISO pulse model for the late-sample test: high from 5 ns to 15 ns after a rising edge
    always @(posedge sclk) begin
        if (pulse_mode) begin
            #5 pulse_v = 1'b1;
            #10 pulse_v = 1'b0;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] xw(input bit s);
        return {s, 19'b0, c_sdel, 2'b0, c_disc, c_lvl, c_own, c_sel, 2'b0, c_cpol, c_cpha};
    endfunction

    task automatic load_tx(input logic [7:0] b);
        wr(A_TXD, {24'b0, b});
        if (txm.size() < DEPTH) txm.push_back(b);
    endtask

    // Driver: computes expected MOSI and RX bytes, runs one burst, polls completion
    task automatic run_burst(input int total, input int txc, input int rxmode, input string tag,
                             input bit do_mid, input logic [3:0] mid_ss);
        logic [31:0] d;
        wr(A_BURST, total);
        wr(A_TXC, txc);
        wr(A_STC, txc);
        for (int i = 0; i < total; i++) begin
            logic [7:0] b;
            b = (i < txc && txm.size() > 0) ? txm.pop_front() : 8'h00;
            mosi_q.push_back(b);
            tag_q.push_back({tag, " R5 MOSI byte"});
            if (!c_disc) rx_q.push_back(rxmode == 0 ? ~b : (rxmode == 1 ? 8'h00 : 8'hFF));
        end
        mbits = 0;
        mon_en = 1'b1;
        wr(A_XFER, xw(1));
        if (do_mid) begin
            repeat (4) @(negedge clk);
            check({tag, " R10 ss during burst"}, {28'b0, ss_n}, {28'b0, mid_ss});
            rd(A_XFER, d);
            check({tag, " R3 start reads 1 while busy"}, {31'b0, d[31]}, 32'd1);
        end
        do rd(A_XFER, d); while (d[31]);
        mon_en = 1'b0;
        check({tag, " R5 all MOSI bytes seen"}, mosi_q.size(), 0);
        rd(A_BURST, d); check({tag, " R4 burst counter 0"}, d, 0);
        rd(A_TXC, d);   check({tag, " R4 tx counter 0"}, d, 0);
        rd(A_STC, d);   check({tag, " R4 single counter 0"}, d, 0);
    endtask

    task automatic drain(input string tag);
        logic [31:0] d;
        while (rx_q.size() > 0) begin
            rd(A_RXD, d);
            check({tag, " R6 RX byte"}, d, {24'b0, rx_q.pop_front()});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic [31:0] d;
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sclk_edges = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 ss_n idle", {28'b0, ss_n}, 32'hF);
        check("R1 sclk low", {31'b0, sclk}, 0);
        check("R1 mosi low", {31'b0, mosi}, 0);
        rd(A_CTRL, d);  check("R1 control", d, 0);
        rd(A_XFER, d);  check("R1 transfer", d, 0);
        rd(A_FIFO, d);  check("R1 fifo control", d, 0);
        rd(A_BURST, d); check("R1 burst counter", d, 0);

        // R2 start ignored while disabled
        wr(A_BURST, 2);
        wr(A_XFER, xw(1));
        rd(A_XFER, d); check("R2 start dropped when off", {31'b0, d[31]}, 0);
        repeat (20) @(negedge clk);
        check("R2 no SCLK when off", sclk_edges, 0);

        wr(A_CTRL, 32'h3);

        // Mode 0 with dummy padding
        load_tx(8'hA5); load_tx(8'h3C); load_tx(8'h81);
        run_burst(5, 3, 0, "mode0", 0, 4'hF);
        drain("mode0");

        // R8 remaining modes
        for (int m = 1; m < 4; m++) begin
            c_cpha = m[0]; c_cpol = m[1];
            wr(A_XFER, xw(0));
            repeat (2) @(negedge clk);
            check("R8 SCLK idle level", {31'b0, sclk}, {31'b0, c_cpol});
            load_tx(8'h5A ^ 8'(m)); load_tx(8'hC3 + 8'(m));
            run_burst(2, 2, 0, "R8 mode", 0, 4'hF);
            drain("R8 mode");
        end
        c_cpha = 0; c_cpol = 0;
        wr(A_XFER, xw(0));

        // R3 zero-length burst
        wr(A_BURST, 0);
        e0 = sclk_edges;
        wr(A_XFER, xw(1));
        rd(A_XFER, d); check("R3 zero burst start cleared", {31'b0, d[31]}, 0);
        check("R3 zero burst no SCLK", sclk_edges - e0, 0);

        // R7 discard
        c_disc = 1;
        load_tx(8'h11); load_tx(8'h22);
        run_burst(2, 2, 0, "R7 discard", 0, 4'hF);
        rd(A_RXD, d); check("R7 nothing stored", d, 0);
        c_disc = 0;

        // R10 chip select
        c_own = 1; c_sel = 2; c_lvl = 0;
        wr(A_XFER, xw(0));
        @(negedge clk); check("R10 owner level low", {28'b0, ss_n}, 32'hB);
        c_lvl = 1;
        wr(A_XFER, xw(0));
        @(negedge clk); check("R10 owner level high", {28'b0, ss_n}, 32'hF);
        c_own = 0; c_sel = 1;
        wr(A_XFER, xw(0));
        run_burst(2, 0, 0, "R10 auto", 1, 4'hD);
        check("R10 auto released", {28'b0, ss_n}, 32'hF);
        drain("R10 auto");

        // R9 late sample
        pulse_mode = 1;
        run_burst(1, 0, 1, "R9 edge sample", 0, 4'hF);
        drain("R9 edge sample");
        c_sdel = 1;
        run_burst(1, 0, 2, "R9 late sample", 0, 4'hF);
        drain("R9 late sample");
        c_sdel = 0; pulse_mode = 0;

        // R11 full TX FIFO and empty RX read
        c_disc = 1;
        for (int i = 0; i <= DEPTH; i++) load_tx(8'(i * 3 + 1));
        run_burst(DEPTH + 1, DEPTH + 1, 0, "R11 overfill", 0, 4'hF);
        c_disc = 0;
        rd(A_RXD, d); check("R11 empty RX read", d, 0);

        // R12 FIFO resets
        wr(A_XFER, xw(0));
        run_burst(1, 0, 0, "R12 prep", 0, 4'hF);
        load_tx(8'h77); load_tx(8'h99);
        wr(A_FIFO, 32'h8000_8000);
        rd(A_FIFO, d); check("R12 reset bits cleared", d, 0);
        txm.delete(); rx_q.delete();
        rd(A_RXD, d); check("R12 RX emptied", d, 0);
        run_burst(1, 1, 0, "R12 TX emptied", 0, 4'hF);
        drain("R12 after reset");

        // R2 abort mid-burst
        wr(A_BURST, 4); wr(A_TXC, 0);
        wr(A_XFER, xw(1));
        repeat (20) @(negedge clk);
        wr(A_CTRL, 0);
        rd(A_XFER, d); check("R2 abort clears start", {31'b0, d[31]}, 0);
        repeat (2) @(negedge clk);
        e0 = sclk_edges;
        repeat (30) @(negedge clk);
        check("R2 abort stops SCLK", sclk_edges - e0, 0);
        rd(A_BURST, d); check("R2 abort leaves count", {31'b0, d != 0}, 1);

        finished = 1;
        report();
    end

endmodule